// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of sixteen general-purpose pins behind a small 16-bit register interface. Software sets each pin's direction, output value and alternate-function select, and reads back the pin levels after a two-flop synchroniser. Every pin can also raise an interrupt. Each pin is set up on its own as edge or level detection, and a polarity bit picks rising or falling for edge mode, or high or low for level mode.

Detected events are held in a per-pin status register. Software clears that register by writing zero to it. A per-pin interrupt mask gates the single summary line `irq` that goes to a higher-level interrupt controller. A separate per-pin sleep mask gates the `wake` line that can bring the system out of sleep. An event always lands in the status register, even when the pin is masked.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the registers hold these values: direction 0x0000, output 0x0000, alternate 0x0000, interrupt mask 0xFFFF, trigger type 0xFFFF, edge polarity 0xFFFF, level polarity 0x0000, interrupt status 0x0000 and sleep mask 0xFFFF. The outputs `irq` and `wake` are 0.
- R2: The register offsets are 0 direction, 1 output, 2 pin level (read only), 3 alternate, 4 interrupt mask, 5 trigger type, 6 edge polarity, 7 level polarity, 8 interrupt status and 9 sleep mask. Writes take effect at the clock edge, and reads are combinational. Offset 2 returns the pins after a two-flop synchroniser. Writes to offset 2 and to offsets 10 to 15 change nothing, and offsets 10 to 15 read as zero.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the output register, and `alt_sel` equals the alternate register.
- R4: A trigger-type bit of 1 selects edge detection. An edge-polarity bit of 1 detects a rising edge and 0 detects a falling edge. A change on `pin_in` shows in the status register after the third following clock edge.
- R5: A trigger-type bit of 0 selects level detection. A level-polarity bit of 1 is active-high and 0 is active-low. The status bit is set on every cycle in which the synchronised level is active.
- R6: An event sets its status bit whatever the mask says. `irq` is 1 exactly when some status bit is set whose mask bit is 0.
- R7: A write to the status register keeps the bits written as 1 and clears the bits written as 0. Writing 0x0000 clears every bit. If a new event hits a bit in the same cycle as a clearing write, the bit stays set.
- R8: `wake` is 1 exactly when some status bit is set whose sleep-mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Output enable per pin |
| alt_sel | output | 16 | Alternate-function select per pin |
| irq | output | 1 | Bank interrupt summary |
| wake | output | 1 | Wake request |

## Verification
The bench targets a level-triggered pin that stays active while software writes zero to the status register. A design that lets the clear win would read back zero there, and an interrupt would be lost. It checks that a pin still records events while its mask bit is set. A design that gated the status register with the mask would then miss any event that happened while the pin was masked. It aims the edge tests at the cycle the event appears. A design missing a synchroniser stage would set status one edge early, and one with mixed-up polarity would fire on the wrong edge. It also runs a random mix of writes, reads and pin toggles and compares each one against a cycle-level reference model. That catches wrong reset values and register offsets that decode the wrong register.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] alt_sel,
  output logic            irq,
  output logic            wake
);
  localparam logic [AW-1:0] A_DIR = 0, A_OUT = 1, A_LVL = 2, A_ALT = 3, A_MSK = 4,
                            A_TRG = 5, A_EPL = 6, A_LPL = 7, A_STA = 8, A_SLP = 9;
  localparam logic [NPIN-1:0] ONES = '1;

  logic [NPIN-1:0] dir_r, out_r, alt_r, msk_r, trg_r, epl_r, lpl_r, sta_r, slp_r;
  logic [NPIN-1:0] sy1, sy2, prv;
  logic [NPIN-1:0] rise, fall, evt;

  assign rise = sy2 & ~prv;
  assign fall = ~sy2 & prv;
  assign evt  = (trg_r & ((epl_r & rise) | (~epl_r & fall)))
              | (~trg_r & ((lpl_r & sy2) | (~lpl_r & ~sy2)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; prv <= '0;
    end else begin
      sy1 <= pin_in; sy2 <= sy1; prv <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_r <= '0; out_r <= '0; alt_r <= '0; msk_r <= ONES;
      trg_r <= ONES; epl_r <= ONES; lpl_r <= '0; slp_r <= ONES;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DIR: dir_r <= reg_wdata;
        A_OUT: out_r <= reg_wdata;
        A_ALT: alt_r <= reg_wdata;
        A_MSK: msk_r <= reg_wdata;
        A_TRG: trg_r <= reg_wdata;
        A_EPL: epl_r <= reg_wdata;
        A_LPL: lpl_r <= reg_wdata;
        A_SLP: slp_r <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta_r <= '0;
    else if (reg_wr && reg_addr == A_STA) sta_r <= (sta_r & reg_wdata) | evt;
    else sta_r <= sta_r | evt;
  end

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_r;
      A_OUT:   reg_rdata = out_r;
      A_LVL:   reg_rdata = sy2;
      A_ALT:   reg_rdata = alt_r;
      A_MSK:   reg_rdata = msk_r;
      A_TRG:   reg_rdata = trg_r;
      A_EPL:   reg_rdata = epl_r;
      A_LPL:   reg_rdata = lpl_r;
      A_STA:   reg_rdata = sta_r;
      A_SLP:   reg_rdata = slp_r;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out = out_r;
  assign pin_oe  = dir_r;
  assign alt_sel = alt_r;
  assign irq     = |(sta_r & ~msk_r);
  assign wake    = |(sta_r & ~slp_r);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN = 16,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] msk,
  input logic [NPIN-1:0] sta,
  input logic [NPIN-1:0] slp,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic            wake
);
  localparam logic [AW-1:0] A_DIR = 0, A_STA = 8;

  a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (msk == '1 && sta == '0 && slp == '1));

  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR) |=> (pin_oe == $past(reg_wdata)));

  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '1) |-> !irq);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STA) |=> ((sta & $past(sta)) == $past(sta)));

  a_r8_sleep_block: assert property (@(posedge clk) disable iff (!rst_n)
    (slp == '1) |-> !wake);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .msk(msk_r), .sta(sta_r), .slp(slp_r),
  .pin_oe(pin_oe), .irq(irq), .wake(wake));

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, pin_in = 0;
  logic [15:0] reg_rdata, pin_out, pin_oe, alt_sel;
  logic        irq, wake;
  int total = 0, bad = 0;
  bit done = 0, live = 0;

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .irq(irq), .wake(wake));

  // reference model from the requirements
  logic [15:0] m [0:9];
  logic [15:0] m1, m2, mp;
  function automatic logic [15:0] m_evt();
    logic [15:0] r = m2 & ~mp, f = ~m2 & mp;
    return (m[5] & ((m[6] & r) | (~m[6] & f))) | (~m[5] & ((m[7] & m2) | (~m[7] & ~m2)));
  endfunction
  function automatic logic [15:0] m_read(input logic [3:0] a);
    if (a == 2) return m2;
    if (a > 9) return 16'h0;
    return m[a];
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m[0] <= 0; m[1] <= 0; m[2] <= 0; m[3] <= 0; m[4] <= '1;
      m[5] <= '1; m[6] <= '1; m[7] <= 0; m[8] <= 0; m[9] <= '1;
      m1 <= 0; m2 <= 0; mp <= 0;
    end else begin
      logic [15:0] e;
      e = m_evt();
      m1 <= pin_in; m2 <= m1; mp <= m2;
      if (reg_wr && reg_addr == 8) m[8] <= (m[8] & reg_wdata) | e;
      else m[8] <= m[8] | e;
      if (reg_wr && reg_addr <= 9 && reg_addr != 2 && reg_addr != 8) m[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live && rst_n) begin
    chk("R6 irq vs model", {15'h0, irq}, {15'h0, |(m[8] & ~m[4])});
    chk("R8 wake vs model", {15'h0, wake}, {15'h0, |(m[8] & ~m[9])});
    chk("R3 pin_oe", pin_oe, m[0]);
    chk("R3 pin_out", pin_out, m[1]);
    chk("R3 alt_sel", alt_sel, m[3]);
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset values
    rd("R1 dir", 0, 16'h0000); rd("R1 out", 1, 16'h0000); rd("R1 alt", 3, 16'h0000);
    rd("R1 mask", 4, 16'hFFFF); rd("R1 trig", 5, 16'hFFFF); rd("R1 epol", 6, 16'hFFFF);
    rd("R1 lpol", 7, 16'h0000); rd("R1 stat", 8, 16'h0000); rd("R1 sleep", 9, 16'hFFFF);
    chk("R1 irq", {15'h0, irq}, 16'h0); chk("R1 wake", {15'h0, wake}, 16'h0);
    live = 1;
    // R3 pin controls
    wr(0, 16'hA5A5); wr(1, 16'h1234); wr(3, 16'h0F0F);
    chk("R3 oe", pin_oe, 16'hA5A5); chk("R3 out", pin_out, 16'h1234); chk("R3 alt", alt_sel, 16'h0F0F);
    // R2 read-only and unmapped offsets
    wr(2, 16'hFFFF); wr(12, 16'hBEEF);
    rd("R2 level ro", 2, 16'h0000); rd("R2 unmapped", 12, 16'h0000); rd("R2 dir kept", 0, 16'hA5A5);
    // R4 rising edge on pin 3, timing
    wr(4, 16'hFFF7);
    pin_in = 16'h0008; cyc(2);
    rd("R4 not yet after 2 edges", 8, 16'h0000);
    cyc(1);
    rd("R4 rising after 3 edges", 8, 16'h0008);
    rd("R2 level reads pin", 2, 16'h0008);
    chk("R6 irq unmasked", {15'h0, irq}, 16'h1);
    // R7 clear
    wr(8, 16'h0000);
    rd("R7 cleared", 8, 16'h0000);
    chk("R7 irq drops", {15'h0, irq}, 16'h0);
    // R4 falling
    wr(6, 16'hFFF7);
    pin_in = 16'h0000; cyc(3);
    rd("R4 falling", 8, 16'h0008);
    wr(8, 16'h0000);
    // R6 masked pin still latches
    pin_in = 16'h0020; cyc(3);
    rd("R6 masked latches", 8, 16'h0020);
    chk("R6 masked no irq", {15'h0, irq}, 16'h0);
    wr(8, 16'h0000);
    // R5 level high on pin 5, R7 event beats clear
    wr(5, 16'hFFDF); wr(7, 16'h0020); wr(4, 16'hFFD7);
    cyc(1);
    rd("R5 level high", 8, 16'h0020);
    chk("R6 level irq", {15'h0, irq}, 16'h1);
    wr(8, 16'h0000);
    rd("R7 event wins over clear", 8, 16'h0020);
    // R8 wake
    chk("R8 sleep blocks", {15'h0, wake}, 16'h0);
    wr(9, 16'hFFDF);
    chk("R8 wake allowed", {15'h0, wake}, 16'h1);
    // R5 level low
    pin_in = 16'h0000; cyc(3); wr(8, 16'h0000);
    rd("R5 inactive clears", 8, 16'h0000);
    wr(7, 16'h0000); cyc(1);
    rd("R5 level low", 8, 16'h0020);
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (16'h1 << $urandom_range(0, 15));
      if (op < 4) begin
        logic [3:0] a = 4'($urandom_range(0, 15));
        logic [15:0] d = (a == 8 && op < 2) ? 16'h0 : 16'($urandom);
        wr(a, d);
      end else begin
        logic [3:0] a = 4'($urandom_range(0, 15));
        rd("R2 random read", a, m_read(a));
        @(negedge clk);
      end
    end
    live = 0; done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule